// File: doc/BRIEF.md
# General-Purpose I/O Port with Bit Read-Modify-Write Sequencer

This block is a parameterised general-purpose I/O port (eight bits by default). It has two registers. The direction register picks, bit by bit, whether a pin is driven by the chip or only observed. The output latch holds the level that each driving pin presents. Software reaches both registers through a small register bus with an address, write and read strobes, and data. A read of the latch address does not return the latch as stored. Each bit is selected separately: a bit set as an input gives the synchronised external pin level, and a bit set as an output gives the latch bit.

A bit-operation sequencer sits beside the registers. It sets, clears, inverts or rewrites one bit of the port in three phases of one clock each. First it reads the port view. Then it changes the selected bit of that captured byte. Last it writes the whole byte back into the latch. Because the captured byte mixes pin levels and latch values, every latch bit behind an input pin is overwritten with the pin level sampled in the read phase. Software that drives bits one at a time must take this into account. A busy flag covers the operation, and a one-cycle done pulse marks its end.

Top module: `gpio_rmw_port`

## Requirements
- R1: After a synchronous reset the direction register and output latch are both zero, so `pin_oe` and `pin_out` are 0x00, and `op_busy` and `op_done` are low.
- R2: A bus write to address 1 loads the direction register. `pin_oe` equals that register, and the new value shows one cycle after the write strobe. A bus read of address 1 returns it. A direction bit of 1 makes the pin an output.
- R3: A bus write to address 0 loads all latch bits, whatever their direction. `pin_out` always presents the latch.
- R4: A bus read of address 0 returns the synchronised pin level for each input bit and the latch bit for each output bit. `bus_rdata` is registered and is valid in the cycle after the read strobe. A pin change reaches the read value only after passing two synchroniser flops.
- R5: `op_kind` selects the bit operation: 2'b00 sets, 2'b01 clears, 2'b10 inverts, 2'b11 rewrites the byte unchanged. `op_bit` gives the bit index.
- R6: A bit operation captures the port view of R4, changes the selected bit, and writes the full byte to the latch. Latch bits of input pins therefore end up equal to the sampled pin levels. Example: direction 0x3F, latch 0x80, pin 7 low, pin 6 high, set bit 0, gives latch 0x41.
- R7: `op_start` is accepted when the sequencer is idle. `op_busy` is high for the three cycles after the accepting edge. The latch takes the new byte at the third edge after acceptance. `op_done` is high for exactly the one cycle after that edge, while `op_busy` is low.
- R8: `op_start` is ignored while `op_busy` is high. The running operation keeps the kind and index captured at acceptance.
- R9: If a bus write to address 0 falls in the same cycle as the sequencer's write phase, the sequencer's byte wins.
- R10: Bus writes to addresses 2 and 3 change nothing, and bus reads of those addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address (0 latch/port, 1 direction) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| op_start | input | 1 | Bit operation request |
| op_kind | input | 2 | Operation code |
| op_bit | input | 3 | Bit index |
| op_busy | output | 1 | Operation in progress |
| op_done | output | 1 | One-cycle completion pulse |
| pin_in | input | 8 | External pin levels |
| pin_out | output | 8 | Levels for driven pins |
| pin_oe | output | 8 | Per-pin output enables |

## Verification
The bench uses the default parameters: eight bits, a two-bit address and two synchroniser stages. With eight bits, every value of the three-bit index, including the top bit 7, can be exercised. The two-bit address leaves two unused addresses on which to check that they have no effect. Two synchroniser stages give a latency short enough to show both the stale read and the fresh read. The vector table uses direction masks that alternate between input and output bits, so the overwrite of R6 shows up in many bit positions.

// File: rtl/gpio_rmw_pkg.sv
package gpio_rmw_pkg;

  typedef enum logic [1:0] {
    BOP_SET  = 2'b00,
    BOP_CLR  = 2'b01,
    BOP_INV  = 2'b10,
    BOP_KEEP = 2'b11
  } bitop_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_READ   = 2'd1,
    PH_MODIFY = 2'd2,
    PH_WRITE  = 2'd3
  } phase_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_sync,
  input  logic              seq_wr,
  input  logic [WIDTH-1:0]  seq_wdata,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  data_q,
  output logic [WIDTH-1:0]  port_view
);

  localparam logic [ADDR_W-1:0] ADDR_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_DIR  = ADDR_W'(1);

  logic wr_data_sel;
  logic wr_dir_sel;

  assign wr_data_sel = bus_wr && (bus_addr == ADDR_DATA);
  assign wr_dir_sel  = bus_wr && (bus_addr == ADDR_DIR);

  // Per-bit port view: pin level for inputs, latch for outputs
  for (genvar b = 0; b < WIDTH; b++) begin : g_view
    assign port_view[b] = dir_q[b] ? data_q[b] : pin_sync[b];
  end

  always_ff @(posedge clk) begin
    if (rst)             dir_q <= '0;
    else if (wr_dir_sel) dir_q <= bus_wdata;
  end

  // Sequencer write has priority over a same-cycle bus write
  always_ff @(posedge clk) begin
    if (rst)              data_q <= '0;
    else if (seq_wr)      data_q <= seq_wdata;
    else if (wr_data_sel) data_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADDR_DATA: bus_rdata <= port_view;
        ADDR_DIR:  bus_rdata <= dir_q;
        default:   bus_rdata <= '0;
      endcase
    end
  end

  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_dir_sel |=> dir_q == $past(bus_wdata)); // R2

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_dir_sel |=> $stable(dir_q)); // R10

  AST_BUS_DATA_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_data_sel && !seq_wr) |=> data_q == $past(bus_wdata)); // R3

  AST_SEQ_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    seq_wr |=> data_q == $past(seq_wdata)); // R9

  AST_RSVD_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr != ADDR_DATA && bus_addr != ADDR_DIR) |=> bus_rdata == '0); // R10

endmodule

// File: rtl/gpio_bitop_seq.sv
module gpio_bitop_seq
  import gpio_rmw_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       kind,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic [WIDTH-1:0] port_view,
  output logic             busy,
  output logic             done,
  output logic             wr_en,
  output logic [WIDTH-1:0] wr_data
);

  phase_e           phase_q;
  bitop_e           kind_q;
  logic [IDX_W-1:0] idx_q;
  logic [WIDTH-1:0] work_q;
  logic [WIDTH-1:0] mask;
  logic [WIDTH-1:0] modified;

  assign mask = {{(WIDTH-1){1'b0}}, 1'b1} << idx_q;

  always_comb begin
    case (kind_q)
      BOP_SET: modified = work_q | mask;
      BOP_CLR: modified = work_q & ~mask;
      BOP_INV: modified = work_q ^ mask;
      default: modified = work_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      kind_q  <= BOP_KEEP;
      idx_q   <= '0;
      work_q  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase_q)
        PH_IDLE: if (start) begin
          kind_q  <= bitop_e'(kind);
          idx_q   <= bit_idx;
          phase_q <= PH_READ;
        end
        PH_READ: begin
          work_q  <= port_view;
          phase_q <= PH_MODIFY;
        end
        PH_MODIFY: begin
          work_q  <= modified;
          phase_q <= PH_WRITE;
        end
        default: begin
          phase_q <= PH_IDLE;
          done    <= 1'b1;
        end
      endcase
    end
  end

  assign busy    = (phase_q != PH_IDLE);
  assign wr_en   = (phase_q == PH_WRITE);
  assign wr_data = work_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R7

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_READ && start) |=> phase_q == PH_MODIFY); // R8

  AST_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy); // R7

endmodule

// File: rtl/gpio_rmw_port.sv
module gpio_rmw_port #(
  parameter int WIDTH       = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic              op_start,
  input  logic [1:0]        op_kind,
  input  logic [IDX_W-1:0]  op_bit,
  output logic              op_busy,
  output logic              op_done,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);

  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] port_view;
  logic [WIDTH-1:0] seq_wdata;
  logic             seq_wr;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] data_q;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst  (rst),
    .din  (pin_in),
    .dout (pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) regs_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_sync  (pin_sync),
    .seq_wr    (seq_wr),
    .seq_wdata (seq_wdata),
    .dir_q     (dir_q),
    .data_q    (data_q),
    .port_view (port_view)
  );

  gpio_bitop_seq #(.WIDTH(WIDTH)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .start     (op_start),
    .kind      (op_kind),
    .bit_idx   (op_bit),
    .port_view (port_view),
    .busy      (op_busy),
    .done      (op_done),
    .wr_en     (seq_wr),
    .wr_data   (seq_wdata)
  );

  assign pin_out = data_q;
  assign pin_oe  = dir_q;

  AST_DONE_LATCH: assert property (@(posedge clk) disable iff (rst)
    op_done |-> pin_out == $past(seq_wdata)); // R6

endmodule

// File: tb/gpio_rmw_port_tb_top.sv
module gpio_rmw_port_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       op_start = 1'b0;
  logic [1:0] op_kind = '0;
  logic [2:0] op_bit = '0;
  logic       op_busy;
  logic       op_done;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  gpio_rmw_port dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .op_start(op_start),
    .op_kind(op_kind), .op_bit(op_bit), .op_busy(op_busy), .op_done(op_done),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  typedef struct packed {
    logic [7:0] dir;
    logic [7:0] latch;
    logic [7:0] pins;
    logic [1:0] kind;
    logic [2:0] bitn;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'h3F, 8'h80, 8'h40, 2'b00, 3'd0, 8'h41},
    '{8'hFF, 8'hA5, 8'h00, 2'b01, 3'd5, 8'h85},
    '{8'h00, 8'hFF, 8'h3C, 2'b10, 3'd7, 8'hBC},
    '{8'h0F, 8'hF0, 8'hA5, 2'b11, 3'd2, 8'hA0},
    '{8'hF0, 8'h0F, 8'h5A, 2'b00, 3'd3, 8'h0A},
    '{8'h55, 8'h33, 8'hCC, 2'b10, 3'd0, 8'h98},
    '{8'hAA, 8'h00, 8'hFF, 2'b01, 3'd1, 8'h55},
    '{8'h81, 8'h7E, 8'h00, 2'b00, 3'd7, 8'h80}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    tick();
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // Full bit operation with cycle-accurate busy/done checks (R7)
  task automatic run_op(input logic [1:0] k, input logic [2:0] b, input logic [7:0] exp, input string req);
    op_kind = k; op_bit = b; op_start = 1'b1;
    tick();
    op_start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R7 busy during op", {7'd0, op_busy}, 8'd1);
      chk("R7 no early done", {7'd0, op_done}, 8'd0);
      tick();
    end
    chk("R7 done pulse", {7'd0, op_done}, 8'd1);
    chk("R7 busy low at done", {7'd0, op_busy}, 8'd0);
    chk(req, pin_out, exp);
    tick();
    chk("R7 done one cycle", {7'd0, op_done}, 8'd0);
  endtask

  initial begin
    logic [7:0] rd;
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R1 reset state
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 busy/done", {6'd0, op_busy, op_done}, 8'h00);
    bus_read(2'd1, rd);
    chk("R1 dir readback", rd, 8'h00);

    // Vector table: R4 read view, R2 enables, R5/R6 operation result
    for (int v = 0; v < NV; v++) begin
      bus_write(2'd1, VECS[v].dir);
      chk("R2 oe next cycle", pin_oe, VECS[v].dir);
      bus_write(2'd0, VECS[v].latch);
      pin_in = VECS[v].pins;
      repeat (3) tick();
      bus_read(2'd0, rd);
      chk("R4 mixed read", rd, (VECS[v].pins & ~VECS[v].dir) | (VECS[v].latch & VECS[v].dir));
      run_op(VECS[v].kind, VECS[v].bitn, VECS[v].exp, "R5 R6 op result");
    end

    // R2 direction readback
    bus_write(2'd1, 8'hC3);
    bus_read(2'd1, rd);
    chk("R2 dir readback", rd, 8'hC3);

    // R3 latch written even when all bits are inputs
    bus_write(2'd1, 8'h00);
    bus_write(2'd0, 8'h5A);
    chk("R3 latch loads behind inputs", pin_out, 8'h5A);
    chk("R3 no enables", pin_oe, 8'h00);

    // R4 synchroniser latency
    pin_in = 8'h00;
    repeat (3) tick();
    pin_in = 8'hFF;
    tick();
    bus_addr = 2'd0; bus_rd = 1'b1;
    tick();
    chk("R4 stale before sync", bus_rdata, 8'h00);
    tick();
    bus_rd = 1'b0;
    chk("R4 fresh after sync", bus_rdata, 8'hFF);

    // R8 start ignored while busy
    bus_write(2'd1, 8'hFF);
    bus_write(2'd0, 8'h00);
    op_kind = 2'b00; op_bit = 3'd2; op_start = 1'b1;
    tick();
    op_kind = 2'b10; op_bit = 3'd7;
    tick();
    tick();
    op_start = 1'b0;
    tick();
    chk("R8 done once", {7'd0, op_done}, 8'd1);
    chk("R8 first request kept", pin_out, 8'h04);
    repeat (5) begin
      tick();
      chk("R8 no second op", {7'd0, op_busy}, 8'd0);
    end
    chk("R8 latch unchanged", pin_out, 8'h04);

    // R9 sequencer wins over same-cycle bus write
    bus_write(2'd0, 8'h00);
    op_kind = 2'b00; op_bit = 3'd1; op_start = 1'b1;
    tick();
    op_start = 1'b0;
    tick();
    tick();
    bus_write(2'd0, 8'hF0);
    chk("R9 sequencer priority", pin_out, 8'h02);

    // R10 reserved addresses
    bus_write(2'd2, 8'hFF);
    bus_write(2'd3, 8'h33);
    bus_read(2'd1, rd);
    chk("R10 dir untouched", rd, 8'hFF);
    chk("R10 latch untouched", pin_out, 8'h02);
    bus_read(2'd3, rd);
    chk("R10 reserved read zero", rd, 8'h00);
    bus_read(2'd2, rd);
    chk("R10 reserved read zero", rd, 8'h00);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule